// File: doc/BRIEF.md
# Posted-Masked Priority Interrupt Controller

This block gathers event lines from a set of hardware sources, such as timers and general-purpose pins. It turns each rising edge into a sticky "posted" flag. A per-source enable mask qualifies the posted flags into pending flags. A fixed-priority chain then picks one winner and turns it into an 8-bit vector-table address. A single request line goes to the CPU, and it is gated by the CPU's global interrupt enable flag. A posted event survives while its mask bit is off, so it fires as soon as software enables it.

Software reaches two registers through a one-bit select. The mask register is read/write. The clear register reads back every posted flag, and a write to it clears each bit written as 0. When the CPU accepts the request by pulsing `irq_taken`, the controller clears the winning source's posted flag. It also freezes the vector for a fixed dispatch window.

A small state machine has two states. `ST_IDLE` presents the live vector and may raise the request. `ST_DISPATCH` holds the captured vector and keeps the request low. The transition *accept* (IDLE to DISPATCH) fires when `irq_taken` is high while `irq_req` is high. The transition *expire* (DISPATCH to IDLE) fires after `DISPATCH_CYC` cycles.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A 0-to-1 change on `src_evt[i]`, compared with its level at the previous clock edge (0 after reset), sets posted bit i at that edge; the bit stays set whatever mask bit i holds.
- R2: Source i is pending only when posted bit i and mask bit i are both 1; `irq_req` is never high without a pending source.
- R3: Writing mask bit i to 1 (`reg_sel`=0) while posted bit i is set raises `irq_req` from the edge of that write, when `gie`=1 and the state is `ST_IDLE`.
- R4: `irq_req` is high only while `gie`=1; raising `gie` while a source is pending in `ST_IDLE` raises `irq_req` in the same cycle, with no clock edge between them.
- R5: `reg_rdata` returns the posted bits when `reg_sel`=1 and the mask bits when `reg_sel`=0, both bit i for source i.
- R6: A write with `reg_sel`=1 clears each posted bit whose `reg_wdata` bit is 0 and leaves bits written as 1 unchanged.
- R7: Source 0 has the highest priority and lower indices win. An accepted `irq_taken` (high while `irq_req` is high) clears the winner's posted bit.
- R8: In `ST_IDLE`, `vec_addr` is 4*(i+1) for winning source i (source 0 gives 0x04), or 0x00 when nothing is pending.
- R9: An accepted `irq_taken` enters `ST_DISPATCH` for `DISPATCH_CYC` cycles. During that window `vec_addr` holds the captured vector and `irq_req` stays low; the block then returns to `ST_IDLE`.
- R10: A rising event on a source in the same cycle as its clear (by register write or by acceptance) leaves its posted bit set.
- R11: After reset, posted and mask bits are 0, `irq_req` is 0 and `vec_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | Event lines, one per source |
| gie | input | 1 | CPU global interrupt enable flag |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mask register, 1 selects the clear/posted register |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_taken | input | 1 | CPU acceptance pulse |
| vec_addr | output | VEC_W | Vector-table address |

## Verification
The bench builds the block with `NUM_SRC`=6 and `DISPATCH_CYC`=4. Six sources are few enough that random events often collide with clear writes and acceptances on the same bit, and often make several sources pending at once. The short dispatch window lets many accept-expire round trips happen. Each of those round trips can also show a higher-priority event arriving while a vector is frozen.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_DISPATCH = 1'b1
    } disp_state_e;

    localparam logic SEL_MASK  = 1'b0;
    localparam logic SEL_CLEAR = 1'b1;
endpackage

// File: rtl/irq_post_bank.sv
`timescale 1ns/1ps
module irq_post_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_evt,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] posted,
    output logic [N-1:0] rise
);
    logic [N-1:0] evt_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = src_evt[i] & ~evt_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_q[i]  <= 1'b0;
                posted[i] <= 1'b0;
            end else begin
                evt_q[i] <= src_evt[i];
                if (rise[i])
                    posted[i] <= 1'b1;
                else if (clr_vec[i])
                    posted[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
    parameter int N        = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_STEP = 4
) (
    input  logic [N-1:0]     pend,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    logic [N:0] lower_any;

    assign lower_any[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign lower_any[i+1] = lower_any[i] | pend[i];
        assign grant[i]       = pend[i] & ~lower_any[i];
    end
    assign any = lower_any[N];

    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i])
                vec = VEC_W'(VEC_STEP * (i + 1));
        end
    end
endmodule

// File: rtl/irq_dispatch_fsm.sv
`timescale 1ns/1ps
module irq_dispatch_fsm
    import pic_pkg::*;
#(
    parameter int VEC_W        = 8,
    parameter int DISPATCH_CYC = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_cand,
    input  logic             taken,
    input  logic [VEC_W-1:0] vec_live,
    output logic             irq_req,
    output logic             accept,
    output logic             in_dispatch,
    output logic [VEC_W-1:0] vec_out
);
    localparam int CNT_W = (DISPATCH_CYC > 1) ? $clog2(DISPATCH_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DISPATCH_CYC - 1);

    disp_state_e      state, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (accept)        state_nxt = ST_DISPATCH;
            ST_DISPATCH: if (cnt_q == '0)   state_nxt = ST_IDLE;
            default:                        state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            vec_q <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                cnt_q <= CNT_LOAD;
                vec_q <= vec_live;
            end else if (state == ST_DISPATCH && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        in_dispatch = 1'b0;
        irq_req     = 1'b0;
        vec_out     = vec_live;
        unique case (state)
            ST_IDLE:     irq_req = req_cand;
            ST_DISPATCH: begin
                in_dispatch = 1'b1;
                vec_out     = vec_q;
            end
            default: ;
        endcase
    end

    assign accept = (state == ST_IDLE) & req_cand & taken;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int VEC_W        = 8,
    parameter int VEC_STEP     = 4,
    parameter int DISPATCH_CYC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               gie,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_req,
    input  logic               irq_taken,
    output logic [VEC_W-1:0]   vec_addr
);
    logic [NUM_SRC-1:0] posted_q, mask_q, rise_v, grant_v, clr_v, pend_v;
    logic               any_pend, accept, in_dispatch;
    logic [VEC_W-1:0]   vec_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_we && reg_sel == SEL_MASK)
            mask_q <= reg_wdata;
    end

    assign clr_v = ((reg_we && reg_sel == SEL_CLEAR) ? ~reg_wdata : '0)
                 | (accept ? grant_v : '0);

    irq_post_bank #(.N(NUM_SRC)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .clr_vec (clr_v),
        .posted  (posted_q),
        .rise    (rise_v)
    );

    assign pend_v = posted_q & mask_q;

    irq_prio_enc #(.N(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) enc_i (
        .pend  (pend_v),
        .grant (grant_v),
        .any   (any_pend),
        .vec   (vec_live)
    );

    irq_dispatch_fsm #(.VEC_W(VEC_W), .DISPATCH_CYC(DISPATCH_CYC)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_cand    (any_pend & gie),
        .taken       (irq_taken),
        .vec_live    (vec_live),
        .irq_req     (irq_req),
        .accept      (accept),
        .in_dispatch (in_dispatch),
        .vec_out     (vec_addr)
    );

    assign reg_rdata = (reg_sel == SEL_CLEAR) ? posted_q : mask_q;
endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gie,
    input logic             irq_req,
    input logic             irq_taken,
    input logic [VEC_W-1:0] vec_addr,
    input logic [N-1:0]     posted,
    input logic [N-1:0]     mask,
    input logic [N-1:0]     rise_v,
    input logic [N-1:0]     grant,
    input logic             in_dispatch
);
    p_event_posts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_v != '0) |=> ((posted & $past(rise_v)) == $past(rise_v)));

    p_req_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((posted & mask) != '0));

    p_req_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    p_gie_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_dispatch && gie && ((posted & mask) != '0)) |-> irq_req);

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_taken_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_taken && ((grant & rise_v) == '0))
            |=> ((posted & $past(grant)) == '0));

    p_dispatch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_dispatch |-> !irq_req);

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dispatch && $past(in_dispatch)) |-> $stable(vec_addr));
endmodule

bind prio_irq_ctrl pic_checker #(.N(NUM_SRC), .VEC_W(VEC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie         (gie),
    .irq_req     (irq_req),
    .irq_taken   (irq_taken),
    .vec_addr    (vec_addr),
    .posted      (posted_q),
    .mask        (mask_q),
    .rise_v      (rise_v),
    .grant       (grant_v),
    .in_dispatch (in_dispatch)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
    localparam int N = 6;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_evt = '0;
    logic         gie = 1'b0;
    logic         reg_we = 1'b0;
    logic         reg_sel = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_req;
    logic         irq_taken = 1'b0;
    logic [7:0]   vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_post, m_mask, m_prev;
    bit           m_disp;
    int           m_cnt;
    logic [7:0]   m_vec;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .DISPATCH_CYC(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .gie(gie),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_taken(irq_taken),
        .vec_addr(vec_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int win_idx(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_vec();
        int w;
        if (m_disp) return m_vec;
        w = win_idx(m_post & m_mask);
        return (w < 0) ? 8'h00 : 8'(4 * (w + 1));
    endfunction

    function automatic bit exp_req(input bit g);
        return !m_disp && g && ((m_post & m_mask) != '0);
    endfunction

    task automatic step(input logic [N-1:0] evt, input bit we, input bit sel,
                        input logic [N-1:0] wd, input bit g, input bit tk);
        logic [N-1:0] clr, rise;
        bit req;
        int w;
        src_evt = evt; reg_we = we; reg_sel = sel; reg_wdata = wd; gie = g; irq_taken = tk;
        #1;
        req = exp_req(g);
        chk("R2", 32'(irq_req), 32'(req));
        chk("R8", 32'(vec_addr), 32'(exp_vec()));
        chk("R5", 32'(reg_rdata), 32'(sel ? m_post : m_mask));
        @(posedge clk);
        w = win_idx(m_post & m_mask);
        rise = evt & ~m_prev;
        clr = (we && sel) ? ~wd : '0;
        if (req && tk) clr[w] = 1'b1;
        if (m_disp) begin
            if (m_cnt == 0) m_disp = 1'b0; else m_cnt--;
        end else if (req && tk) begin
            m_vec = exp_vec();
            m_disp = 1'b1;
            m_cnt = D - 1;
        end
        m_post = (m_post & ~clr) | rise;
        if (we && !sel) m_mask = wd;
        m_prev = evt;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_post = '0; m_mask = '0; m_prev = '0; m_disp = 1'b0; m_cnt = 0; m_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 req", 32'(irq_req), 0);
        chk("R11 vec", 32'(vec_addr), 0);
        chk("R11 mask", 32'(reg_rdata), 0);
        reg_sel = 1'b1; #1;
        chk("R11 posted", 32'(reg_rdata), 0);
        @(negedge clk);

        // masked event is posted but not requested
        step(6'b000100, 0, 1, '0, 1, 0);
        #1;
        chk("R1 posted while masked", 32'(reg_rdata), 32'h04);
        chk("R2 masked no req", 32'(irq_req), 0);
        // enabling the mask fires the posted event
        step(6'b000000, 1, 0, 6'b000100, 1, 0);
        #1;
        chk("R3 req after mask", 32'(irq_req), 1);
        chk("R8 vec src2", 32'(vec_addr), 32'h0C);
        // gie gating
        step(6'b000000, 0, 0, '0, 0, 0);
        #1;
        chk("R4 gie low", 32'(irq_req), 0);
        gie = 1'b1; #1;
        chk("R4 gie rise same cycle", 32'(irq_req), 1);
        // priority: source 0 beats source 2
        step(6'b000001, 1, 0, 6'b111111, 1, 0);
        #1;
        chk("R7 src0 wins", 32'(vec_addr), 32'h04);
        // accept
        step(6'b000000, 0, 1, '0, 1, 1);
        #1;
        chk("R9 req low", 32'(irq_req), 0);
        chk("R9 vec held", 32'(vec_addr), 32'h04);
        chk("R7 src0 cleared", 32'(reg_rdata), 32'h04);
        // higher-priority event during dispatch
        step(6'b000010, 0, 1, '0, 1, 0);
        #1;
        chk("R9 vec frozen", 32'(vec_addr), 32'h04);
        step(6'b000000, 0, 1, '0, 1, 0);
        step(6'b000000, 0, 1, '0, 1, 0);
        #1;
        chk("R9 still dispatch", 32'(irq_req), 0);
        step(6'b000000, 0, 1, '0, 1, 0);
        #1;
        chk("R9 back to idle", 32'(irq_req), 1);
        chk("R7 next winner", 32'(vec_addr), 32'h08);
        chk("R1 posted bits", 32'(reg_rdata), 32'h06);
        // clear write
        step(6'b000000, 1, 1, 6'b111011, 0, 0);
        #1;
        chk("R6 zero clears one keeps", 32'(reg_rdata), 32'h02);
        // event colliding with clear
        step(6'b000000, 1, 1, 6'b111101, 0, 0);
        step(6'b000010, 1, 1, 6'b111101, 0, 0);
        #1;
        chk("R10 event beats clear", 32'(reg_rdata), 32'h02);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] e, wd;
            bit we, sel, g, tk;
            e   = N'($urandom);
            we  = ($urandom % 4) == 0;
            sel = $urandom % 2;
            wd  = sel ? N'($urandom | $urandom | $urandom) : N'($urandom);
            g   = ($urandom % 4) != 0;
            tk  = ($urandom % 3) == 0;
            step(e, we, sel, wd, g, tk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule